// File: doc/BRIEF.md
# Infrared Low-Power Pulse Timing Unit

This block sits beside an infrared serial encoder and decoder. It supplies a low-power timing tick, shapes outgoing infrared pulses and screens incoming ones. Software programs an 8-bit divisor. The block counts system clock cycles against that divisor and raises a one-cycle enable strobe, the tick, once per period. The tick is meant to run near 1.8432 MHz, and its usable range is 1.42 to 2.12 MHz. A divisor of zero is illegal and stops the tick entirely.

When the encoder asks for a pulse, the block waits for the next tick. It then drives the transmit line high for exactly three tick periods, which gives roughly 1.41 to 2.11 µs across the legal tick range.

On the receive side, the raw infrared line passes through a two-flop synchronizer. The block then measures how long the line stays high, in system clock cycles. A pulse that lasts at least one tick period produces a single accept strobe. Anything shorter is treated as a glitch and dropped.

Top module: `irlp_pulse_gen`

## Requirements
- R1: Synchronous active-low reset sets the divisor to zero and leaves the tick, the transmit line and the accept strobe at 0; no tick appears after reset until a nonzero divisor is written.
- R2: With active divisor P (1 to 255), the tick is high for exactly one cycle every P cycles; with P = 1 it is high every cycle.
- R3: While the active divisor is zero, no tick is produced, a transmit request never produces a pulse, and no receive pulse is accepted.
- R4: A divisor written while the tick is running takes effect only after the current period ends at the old length. A write made while the tick is stopped is adopted two cycles after the write cycle, and the first tick then follows P cycles later.
- R5: After a request (tx_req high for one cycle), the transmit line rises in the cycle after the next tick. It stays high for exactly 3 × P cycles, ending in the cycle after the third subsequent tick.
- R6: Requests that arrive while a pulse is waiting for its starting tick, or while a pulse is being driven, are dropped; each accepted request yields exactly one pulse.
- R7: The receive line is active high. If it is sampled high on P consecutive clock edges, rx_pulse_ok goes high for one cycle, visible after the edge that follows those P samples.
- R8: A receive pulse sampled high on fewer than P consecutive edges produces no strobe.
- R9: A receive pulse, however long, produces at most one strobe, including pulses that outlast a 255-cycle counter range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr | input | 1 | Divisor write enable, one cycle |
| div_wdata | input | 8 | Divisor value written when div_wr is high |
| tx_req | input | 1 | Request one shaped infrared pulse |
| ir_rx_in | input | 1 | Raw infrared receive line, asynchronous, active high |
| lp_tick | output | 1 | Low-power tick, one system clock wide |
| ir_tx_out | output | 1 | Shaped transmit pulse, three ticks wide |
| rx_pulse_ok | output | 1 | One-cycle strobe for a receive pulse accepted as valid |

## Verification
A wrong divider count first shows up as a tick landing one or more cycles early or late, within a single period of at most 255 cycles. Since every output is timed from the tick, a divider fault then spreads into transmit pulse edges and into the width needed for a receive pulse to be accepted. A wrong transmit state shows up as a missing pulse, an extra pulse, or a falling edge displaced from a tick boundary, within three periods. A corrupted run counter in the receive filter causes a strobe that arrives at the wrong cycle, a repeated strobe, or acceptance of a pulse one cycle short. All of these are caught because the bench compares every output on every clock.

// File: rtl/irlp_pkg.sv
// Shared types for the infrared low-power pulse timing unit.
// Assumes: nothing beyond standard SystemVerilog packages.
package irlp_pkg;

    // Transmit shaper phases
    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,   // no request outstanding
        TXS_ARMED = 2'd1,   // request taken, waiting for the starting tick
        TXS_EMIT  = 2'd2    // pulse being driven
    } txs_state_e;

endpackage

// File: rtl/irlp_tick_div.sv
// Programmable divider that produces the low-power tick as a one-cycle enable.
// Holds a written divisor and an active divisor. The active value is refreshed
// from the written one at each terminal count, or at once while stopped (zero).
// Assumes: a zero divisor means the tick is switched off.
module irlp_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic             tick,
    output logic [DIV_W-1:0] period
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] wdiv_q;
    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;

    // Purpose: capture software writes to the divisor
    always_ff @(posedge clk) begin
        if (!rst_n)     wdiv_q <= '0;
        else if (wr_en) wdiv_q <= wr_data;
    end

    // Purpose: count cycles and adopt the written divisor at period boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (act_q == '0 || tick) begin
            act_q <= wdiv_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Purpose: tick on the last cycle of each period
    always_comb tick = (act_q != '0) && (cnt_q == act_q - ONE);

    assign period = act_q;

endmodule

// File: rtl/irlp_tx_shaper.sv
// Shapes one transmit pulse per accepted request, aligned to tick boundaries
// and PULSE_TICKS tick periods wide.
// Assumes: requests that arrive while busy are dropped by design.
module irlp_tx_shaper
    import irlp_pkg::*;
#(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic pulse
);

    localparam int             CW    = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0]  LAST  = CW'(PULSE_TICKS - 1);
    localparam logic [CW-1:0]  ONE_C = {{(CW-1){1'b0}}, 1'b1};

    txs_state_e    state_q;
    logic [CW-1:0] tcnt_q;

    // Purpose: step through idle, armed and emit phases on requests and ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXS_IDLE;
            tcnt_q  <= '0;
        end else begin
            unique case (state_q)
                TXS_IDLE: if (req) state_q <= TXS_ARMED;
                TXS_ARMED: if (tick) begin
                    state_q <= TXS_EMIT;
                    tcnt_q  <= '0;
                end
                TXS_EMIT: if (tick) begin
                    if (tcnt_q == LAST) state_q <= TXS_IDLE;
                    else                tcnt_q  <= tcnt_q + ONE_C;
                end
                default: state_q <= TXS_IDLE;
            endcase
        end
    end

    // Purpose: the line is high only during the emit phase
    always_comb pulse = (state_q == TXS_EMIT);

endmodule

// File: rtl/irlp_rx_filter.sv
// Synchronizes the raw receive line and accepts a high pulse once it has
// lasted one full tick period in system clocks, giving one strobe per pulse.
// Assumes: the line is active high and asynchronous to clk.
module irlp_rx_filter #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_raw,
    input  logic [DIV_W-1:0] period,
    output logic             line,
    output logic             hit
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [SYNC_STAGES-1:0] sync_q;
    logic [DIV_W-1:0]       run_q;

    // Purpose: build the synchronizer chain one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n)      sync_q[g] <= 1'b0;
            else if (g == 0) sync_q[g] <= rx_raw;
            else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
    end

    assign line = sync_q[SYNC_STAGES-1];

    // Purpose: count consecutive high cycles, saturating at full scale
    always_ff @(posedge clk) begin
        if (!rst_n || !line)  run_q <= '0;
        else if (run_q != '1) run_q <= run_q + ONE;
    end

    // Purpose: strobe exactly when the run reaches one tick period
    always_comb hit = line && (period != '0) && (run_q == period - ONE);

endmodule

// File: rtl/irlp_pulse_gen.sv
// Top of the infrared low-power pulse timing unit: tick divider, transmit
// pulse shaper and receive glitch filter sharing one active divisor.
// Assumes: one clock domain; the receive line is the only asynchronous input.
module irlp_pulse_gen #(
    parameter int DIV_W       = 8,
    parameter int PULSE_TICKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             tx_req,
    input  logic             ir_rx_in,
    output logic             lp_tick,
    output logic             ir_tx_out,
    output logic             rx_pulse_ok
);

    logic [DIV_W-1:0] period_w;
    logic             rx_line_w;

    irlp_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (div_wr),
        .wr_data (div_wdata),
        .tick    (lp_tick),
        .period  (period_w)
    );

    irlp_tx_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (lp_tick),
        .req   (tx_req),
        .pulse (ir_tx_out)
    );

    irlp_rx_filter #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_raw (ir_rx_in),
        .period (period_w),
        .line   (rx_line_w),
        .hit    (rx_pulse_ok)
    );

endmodule

// File: rtl/irlp_pulse_gen_chk.sv
// Property checker for irlp_pulse_gen, attached by bind below.
// Assumes: reset is synchronous and active low.
module irlp_pulse_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [DIV_W-1:0] period,
    input logic             tx_pulse,
    input logic             rx_line,
    input logic             rx_ok
);

    // R3: no tick while the active divisor is zero
    a_r3_no_tick_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !tick);

    // R2: a tick is one cycle wide unless the next period is one cycle
    a_r2_tick_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || period == 1));

    // R5: the transmit line rises only on a tick boundary
    a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pulse) |-> $past(tick));

    // R5: the transmit line falls only on a tick boundary
    a_r5_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_pulse) |-> $past(tick));

    // R7: acceptance requires the synchronized line to be high
    a_r7_ok_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |-> rx_line);

    // R8: with a multi-cycle period the line was already high a cycle earlier
    a_r8_ok_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && period > 1) |-> $past(rx_line));

    // R9: never two strobes back to back
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok);

endmodule

bind irlp_pulse_gen irlp_pulse_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (lp_tick),
    .period   (period_w),
    .tx_pulse (ir_tx_out),
    .rx_line  (rx_line_w),
    .rx_ok    (rx_pulse_ok)
);

// File: tb/sim_irlp_pulse_gen.sv
// Bench: behavioural reference model compared against the design every clock.
module sim_irlp_pulse_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       tx_req = 1'b0;
    logic       ir_rx_in = 1'b0;
    logic       lp_tick, ir_tx_out, rx_pulse_ok;

    int vectors = 0;
    int miscompares = 0;
    bit comparing = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    irlp_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .tx_req(tx_req), .ir_rx_in(ir_rx_in), .lp_tick(lp_tick),
        .ir_tx_out(ir_tx_out), .rx_pulse_ok(rx_pulse_ok)
    );

    // ---------------- reference model ----------------
    int m_wdiv = 0, m_act = 0, m_cnt = 0;
    int m_txph = 0, m_txn = 0;             // 0 idle, 1 waiting, 2 driving
    int m_s1 = 0, m_s2 = 0, m_run = 0;

    function automatic bit exp_tick();
        return (m_act != 0) && (m_cnt == m_act - 1);
    endfunction
    function automatic bit exp_tx();
        return m_txph == 2;
    endfunction
    function automatic bit exp_ok();
        return (m_s2 != 0) && (m_act != 0) && (m_run == m_act - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wdiv = 0; m_act = 0; m_cnt = 0;
            m_txph = 0; m_txn = 0;
            m_s1 = 0; m_s2 = 0; m_run = 0;
        end else begin
            automatic bit t = exp_tick();
            if (m_act == 0 || t) begin m_act = m_wdiv; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
            if (div_wr) m_wdiv = div_wdata;
            if (m_txph == 0) begin
                if (tx_req) m_txph = 1;
            end else if (m_txph == 1) begin
                if (t) begin m_txph = 2; m_txn = 0; end
            end else if (t) begin
                if (m_txn == 2) m_txph = 0; else m_txn = m_txn + 1;
            end
            if (m_s2 != 0) m_run = (m_run < 255) ? m_run + 1 : 255;
            else           m_run = 0;
            m_s2 = m_s1;
            m_s1 = ir_rx_in;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (comparing && !finished) begin
            check("R2 R3 R4", "lp_tick", lp_tick, exp_tick());
            check("R5 R6", "ir_tx_out", ir_tx_out, exp_tx());
            check("R7 R8 R9", "rx_pulse_ok", rx_pulse_ok, exp_ok());
        end
    end

    // Output-side counters and transmit width monitor
    int tx_pulses = 0, rx_hits = 0, tick_seen = 0;
    int tx_len = 0, tx_exp_len = 0;
    always @(negedge clk) begin
        if (comparing && !finished) begin
            if (rx_pulse_ok) rx_hits++;
            if (lp_tick) tick_seen++;
            if (ir_tx_out) begin
                if (tx_len == 0) begin tx_pulses++; tx_exp_len = 3 * m_act; end
                tx_len++;
            end else if (tx_len != 0) begin
                check("R5", "tx pulse width", tx_len, tx_exp_len);
                tx_len = 0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic write_div(input int v);
        @(negedge clk); div_wr = 1'b1; div_wdata = 8'(v);
        @(negedge clk); div_wr = 1'b0;
    endtask
    task automatic request();
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask
    task automatic rx_pulse(input int w);
        @(negedge clk); ir_rx_in = 1'b1;
        cyc(w);
        ir_rx_in = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

    initial begin
        int gap;
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        comparing = 1;
        // R1: reset state
        check("R1", "lp_tick after reset", lp_tick, 0);
        check("R1", "ir_tx_out after reset", ir_tx_out, 0);
        check("R1", "rx_pulse_ok after reset", rx_pulse_ok, 0);
        tick_seen = 0;
        cyc(20);
        check("R1", "ticks with reset divisor", tick_seen, 0);

        // R3: zero divisor, request and receive pulse do nothing
        request();
        rx_pulse(20);
        cyc(20);
        check("R3", "tx pulses with zero divisor", tx_pulses, 0);
        check("R3", "rx accepts with zero divisor", rx_hits, 0);

        // R4/R5: enabling the divisor releases the waiting request
        write_div(4);
        cyc(60);
        check("R5", "tx pulses after enable", tx_pulses, 1);

        // R6: repeated requests while busy
        tx_pulses = 0;
        request(); cyc(2); request(); cyc(2); request(); cyc(2); request();
        cyc(40);
        check("R6", "tx pulses from burst", tx_pulses, 1);

        // R4: change divisor mid-period, then measure spacing
        cyc(1);
        write_div(7);
        cyc(50);
        while (!lp_tick) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!lp_tick);
        check("R2", "tick spacing with divisor 7", gap, 7);

        // R7/R8/R9 at P = 7
        rx_hits = 0;
        rx_pulse(6); cyc(20);
        check("R8", "accepts for short pulse", rx_hits, 0);
        rx_pulse(7); cyc(20);
        check("R7", "accepts for minimum pulse", rx_hits, 1);
        rx_pulse(40); cyc(20);
        check("R9", "accepts after long pulse", rx_hits, 2);

        // Divisor 1: tick every cycle
        write_div(1);
        cyc(20);
        tick_seen = 0;
        cyc(10);
        check("R2", "ticks in 10 cycles at divisor 1", tick_seen, 10);
        tx_pulses = 0; rx_hits = 0;
        request(); cyc(10);
        rx_pulse(1); cyc(10);
        check("R5", "tx pulses at divisor 1", tx_pulses, 1);
        check("R7", "accepts one-cycle pulse at divisor 1", rx_hits, 1);

        // Divisor 255: widest pulses, saturating run counter
        write_div(255);
        cyc(300);
        rx_hits = 0; tx_pulses = 0;
        rx_pulse(254); cyc(10);
        check("R8", "accepts for 254-cycle pulse", rx_hits, 0);
        rx_pulse(300); cyc(10);
        check("R9", "accepts for 300-cycle pulse", rx_hits, 1);
        request();
        cyc(1100);
        check("R5", "tx pulses at divisor 255", tx_pulses, 1);

        // R3: writing zero stops the tick after the current period
        write_div(0);
        cyc(300);
        tick_seen = 0;
        cyc(300);
        check("R3", "ticks after zero write", tick_seen, 0);

        finish_run();
    end

endmodule